// File: doc/BRIEF.md
# Hamming Sector ECC Checker

This block judges one 512-byte NAND sector after it has been read. It takes two 3-byte Hamming codes: the code kept in the page's spare area and the code computed from the data as it streamed in. It says whether the sector is clean, holds one flipped data bit (and where that bit is), has a damaged code, is a blank erased page, or cannot be repaired. Each check is started by a one-cycle strobe. The verdict comes back with a one-cycle done pulse.

Both codes are unpacked into 32-bit words and XORed into a syndrome. The set bits of the syndrome are counted with a small adder tree. Parameter `PIPE` puts a register stage inside that tree, so timing can be traded against one extra cycle of latency. When a single data bit is wrong and the repair port is enabled, the block also issues one write to the sector buffer. That write carries the byte address and a one-hot mask that the buffer XORs into the stored byte.

Top module: `ham_sector_chk`

## Requirements
- R1: Each code input carries byte0 in bits 7:0, byte1 in bits 15:8 and byte2 in bits 23:16. It unpacks into a 32-bit word with byte0 at bits 7:0, the low nibble of byte2 at bits 11:8, byte1 at bits 23:16 and the high nibble of byte2 at bits 27:24. All other bits are zero.
- R2: When the syndrome (stored word XOR computed word) is zero, the status is 0 (clean).
- R3: When the syndrome has exactly 12 set bits, the status is 1 (corrected). The error byte output is syndrome bits 27:19 and the error bit output is syndrome bits 18:16.
- R4: When the syndrome has exactly 1 set bit, the status is 2 (damaged code). In every result whose status is not 1, the error byte and error bit outputs are 0.
- R5: When the unpacked stored word is 0x0FFF0FFF (all three stored bytes are 0xFF) and the unpacked computed word is zero, the status is 3 (erased page).
- R6: Any other nonzero syndrome gives status 4 (uncorrectable).
- R7: `chk_done_o` pulses for one cycle, one clock after the sampled `chk_valid_i` when `PIPE`=0 and two clocks after it when `PIPE`=1. The status and error outputs hold their values between done pulses.
- R8: With `FIX_PORT`=1, `fix_we_o` pulses together with `chk_done_o` only when the status is 1. `fix_addr_o` then equals the error byte and `fix_mask_o` equals 1 shifted left by the error bit.
- R9: During and after reset, `chk_done_o` and `fix_we_o` are 0, and the status, error byte, error bit, address and mask outputs are 0.
- R10: A strobe on every consecutive cycle yields one result per cycle, delivered in strobe order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chk_valid_i | input | 1 | Starts a check of the two codes on this cycle |
| stored_code_i | input | 24 | Code read from the spare area, {byte2, byte1, byte0} |
| calc_code_i | input | 24 | Code computed from the sector data, {byte2, byte1, byte0} |
| chk_done_o | output | 1 | Result valid pulse |
| chk_status_o | output | 3 | 0 clean, 1 corrected, 2 damaged code, 3 erased, 4 uncorrectable |
| err_byte_o | output | 9 | Byte index of the flipped bit within the sector |
| err_bit_o | output | 3 | Bit index of the flipped bit within the byte |
| fix_we_o | output | 1 | Sector buffer repair write strobe |
| fix_addr_o | output | 9 | Repair byte address |
| fix_mask_o | output | 8 | One-hot mask to XOR into the byte |

## Verification
The embedded properties watch the timing contract on every cycle. They check the done latency, that the outputs hold between results, and that a repair write happens only with a corrected verdict and agrees with the reported location. They also check that the error location is zero for every other verdict and that identical codes always come back clean.

The classification itself is shown only by the bench's sweeps. These cover all 4096 single-bit data locations, all 24 single-bit code faults, the erased-page signature and its near misses, a set of double faults, and a burst of back-to-back strobes. Each sweep runs against both pipeline settings, and the expected verdict is computed from popcounts in the bench.

// File: rtl/ham_chk_pkg.sv
package ham_chk_pkg;
  localparam int BYTE_W   = 8;
  localparam int CODE_W   = 3 * BYTE_W;
  localparam int WORD_W   = 32;
  localparam int HALF_LSB = 16;

  typedef enum logic [2:0] {
    ST_CLEAN    = 3'd0,
    ST_FIXED    = 3'd1,
    ST_CODE_BAD = 3'd2,
    ST_BLANK    = 3'd3,
    ST_FATAL    = 3'd4
  } chk_status_e;

  localparam logic [WORD_W-1:0] BLANK_SIG = 32'h0FFF_0FFF;
endpackage

// File: rtl/ham_rst_sync.sv
module ham_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ham_code_unpack.sv
module ham_code_unpack
  import ham_chk_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int NIB_W = BYTE_W / 2;

  logic [BYTE_W-1:0] b0, b1, b2;

  assign b0 = code_i[0*BYTE_W +: BYTE_W];
  assign b1 = code_i[1*BYTE_W +: BYTE_W];
  assign b2 = code_i[2*BYTE_W +: BYTE_W];

  // low half carries the complement-side parity, high half the location side
  assign word_o = {{NIB_W{1'b0}}, b2[BYTE_W-1 -: NIB_W], b1,
                   {NIB_W{1'b0}}, b2[NIB_W-1:0],        b0};
endmodule

// File: rtl/ham_popcnt.sv
module ham_popcnt #(
  parameter int W      = 32,
  parameter int GROUPS = 2
) (
  input  logic [W-1:0]                            vec_i,
  output logic [GROUPS*$clog2(W/GROUPS+1)-1:0]    part_o
);
  localparam int GW  = W / GROUPS;
  localparam int GCW = $clog2(GW + 1);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    logic [GCW-1:0] sum;
    always_comb begin
      sum = '0;
      for (int b = 0; b < GW; b++) sum = sum + GCW'(vec_i[g*GW + b]);
    end
    assign part_o[g*GCW +: GCW] = sum;
  end
endmodule

// File: rtl/ham_classify.sv
module ham_classify
  import ham_chk_pkg::*;
#(
  parameter int IDX_W = 9,
  parameter int BIT_W = 3,
  parameter int CNT_W = 6
) (
  input  logic [WORD_W-1:0] syn_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              blank_i,
  output chk_status_e       status_o,
  output logic [IDX_W-1:0]  byte_o,
  output logic [BIT_W-1:0]  bit_o
);
  localparam int FIX_WEIGHT = 12;

  always_comb begin
    status_o = ST_FATAL;
    byte_o   = '0;
    bit_o    = '0;
    if (syn_i == '0) begin
      status_o = ST_CLEAN;
    end else if (cnt_i == CNT_W'(FIX_WEIGHT)) begin
      status_o = ST_FIXED;
      bit_o    = syn_i[HALF_LSB +: BIT_W];
      byte_o   = syn_i[HALF_LSB + BIT_W +: IDX_W];
    end else if (cnt_i == CNT_W'(1)) begin
      status_o = ST_CODE_BAD;
    end else if (blank_i) begin
      status_o = ST_BLANK;
    end
  end
endmodule

// File: rtl/ham_sector_chk.sv
module ham_sector_chk
  import ham_chk_pkg::*;
#(
  parameter int PIPE         = 0,
  parameter int FIX_PORT     = 1,
  parameter int SECTOR_BYTES = 512
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             chk_valid_i,
  input  logic [23:0]                      stored_code_i,
  input  logic [23:0]                      calc_code_i,
  output logic                             chk_done_o,
  output logic [2:0]                       chk_status_o,
  output logic [$clog2(SECTOR_BYTES)-1:0]  err_byte_o,
  output logic [2:0]                       err_bit_o,
  output logic                             fix_we_o,
  output logic [$clog2(SECTOR_BYTES)-1:0]  fix_addr_o,
  output logic [7:0]                       fix_mask_o
);
  localparam int IDX_W  = $clog2(SECTOR_BYTES);
  localparam int BIT_W  = 3;
  localparam int GROUPS = 2;
  localparam int GCW    = $clog2(WORD_W/GROUPS + 1);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int PW     = GROUPS * GCW;

  logic rst_n;
  ham_rst_sync #(.STAGES(2)) u_rst (.clk_i(clk_i), .rst_ni(rst_ni), .rst_no(rst_n));

  // stage 0: unpack, syndrome, partial counts
  logic [WORD_W-1:0] st_w, ca_w, s0_syn;
  logic              s0_blank;
  logic [PW-1:0]     s0_part;

  ham_code_unpack u_unp_st (.code_i(stored_code_i), .word_o(st_w));
  ham_code_unpack u_unp_ca (.code_i(calc_code_i),   .word_o(ca_w));

  assign s0_syn   = st_w ^ ca_w;
  assign s0_blank = (st_w == BLANK_SIG) && (ca_w == '0);

  ham_popcnt #(.W(WORD_W), .GROUPS(GROUPS)) u_pop (.vec_i(s0_syn), .part_o(s0_part));

  // optional mid-tree register
  logic              s1_vld;
  logic [WORD_W-1:0] s1_syn;
  logic              s1_blank;
  logic [PW-1:0]     s1_part;

  if (PIPE != 0) begin : g_pipe
    logic              vld_q, vld_d;
    logic [WORD_W-1:0] syn_q, syn_d;
    logic              blank_q, blank_d;
    logic [PW-1:0]     part_q, part_d;

    always_comb begin
      vld_d   = chk_valid_i;
      syn_d   = chk_valid_i ? s0_syn   : syn_q;
      blank_d = chk_valid_i ? s0_blank : blank_q;
      part_d  = chk_valid_i ? s0_part  : part_q;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        vld_q   <= 1'b0;
        syn_q   <= '0;
        blank_q <= 1'b0;
        part_q  <= '0;
      end else begin
        vld_q   <= vld_d;
        syn_q   <= syn_d;
        blank_q <= blank_d;
        part_q  <= part_d;
      end
    end

    assign s1_vld   = vld_q;
    assign s1_syn   = syn_q;
    assign s1_blank = blank_q;
    assign s1_part  = part_q;
  end else begin : g_flat
    assign s1_vld   = chk_valid_i;
    assign s1_syn   = s0_syn;
    assign s1_blank = s0_blank;
    assign s1_part  = s0_part;
  end

  // final adder and classification
  logic [CNT_W-1:0] s1_cnt;
  always_comb begin
    s1_cnt = '0;
    for (int g = 0; g < GROUPS; g++) s1_cnt = s1_cnt + CNT_W'(s1_part[g*GCW +: GCW]);
  end

  chk_status_e      cls_status;
  logic [IDX_W-1:0] cls_byte;
  logic [BIT_W-1:0] cls_bit;

  ham_classify #(.IDX_W(IDX_W), .BIT_W(BIT_W), .CNT_W(CNT_W)) u_cls (
    .syn_i(s1_syn), .cnt_i(s1_cnt), .blank_i(s1_blank),
    .status_o(cls_status), .byte_o(cls_byte), .bit_o(cls_bit)
  );

  // result registers
  logic             done_q, done_d;
  logic [2:0]       status_q, status_d;
  logic [IDX_W-1:0] byte_q, byte_d;
  logic [BIT_W-1:0] bit_q, bit_d;

  always_comb begin
    done_d   = s1_vld;
    status_d = s1_vld ? 3'(cls_status) : status_q;
    byte_d   = s1_vld ? cls_byte       : byte_q;
    bit_d    = s1_vld ? cls_bit        : bit_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      status_q <= '0;
      byte_q   <= '0;
      bit_q    <= '0;
    end else begin
      done_q   <= done_d;
      status_q <= status_d;
      byte_q   <= byte_d;
      bit_q    <= bit_d;
    end
  end

  assign chk_done_o   = done_q;
  assign chk_status_o = status_q;
  assign err_byte_o   = byte_q;
  assign err_bit_o    = bit_q;

  if (FIX_PORT != 0) begin : g_fix
    logic             we_q, we_d;
    logic [IDX_W-1:0] addr_q, addr_d;
    logic [7:0]       mask_q, mask_d;
    logic             hit;

    assign hit = s1_vld && (cls_status == ST_FIXED);

    always_comb begin
      we_d   = hit;
      addr_d = hit ? cls_byte              : addr_q;
      mask_d = hit ? (8'b1 << cls_bit)     : mask_q;
    end

    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) begin
        we_q   <= 1'b0;
        addr_q <= '0;
        mask_q <= '0;
      end else begin
        we_q   <= we_d;
        addr_q <= addr_d;
        mask_q <= mask_d;
      end
    end

    assign fix_we_o   = we_q;
    assign fix_addr_o = addr_q;
    assign fix_mask_o = mask_q;

    assert_fix_only_fixed_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
      fix_we_o |-> (chk_done_o && chk_status_o == 3'(ST_FIXED)));
    assert_fix_every_fixed_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
      (chk_done_o && chk_status_o == 3'(ST_FIXED)) |-> fix_we_o);
    assert_fix_target_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
      fix_we_o |-> (fix_addr_o == err_byte_o && fix_mask_o == (8'b1 << err_bit_o)));
  end else begin : g_nofix
    assign fix_we_o   = 1'b0;
    assign fix_addr_o = '0;
    assign fix_mask_o = '0;
  end

  // timing contract
  if (PIPE != 0) begin : g_lat2
    assert_done_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
      chk_done_o |-> $past(chk_valid_i, 2));
  end else begin : g_lat1
    assert_done_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
      chk_done_o |-> $past(chk_valid_i));
    assert_same_is_clean_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
      (chk_done_o && $past(stored_code_i == calc_code_i)) |-> chk_status_o == 3'(ST_CLEAN));
  end

  assert_hold_between_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !chk_done_o |-> ($stable(chk_status_o) && $stable(err_byte_o) && $stable(err_bit_o)));
  assert_idx_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (chk_done_o && chk_status_o != 3'(ST_FIXED)) |-> (err_byte_o == '0 && err_bit_o == '0));
  assert_status_range_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    chk_done_o |-> chk_status_o <= 3'(ST_FATAL));
endmodule

// File: tb/test_ham_sector_chk.sv
module test_ham_sector_chk;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vld;
  logic [23:0] st, ca;

  logic        a_done, b_done, a_we, b_we;
  logic [2:0]  a_stat, b_stat, a_bit, b_bit;
  logic [8:0]  a_byte, b_byte, a_addr, b_addr;
  logic [7:0]  a_mask, b_mask;

  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ham_sector_chk #(.PIPE(0)) i_ham_sector_chk (
    .clk_i(clk), .rst_ni(rst_n), .chk_valid_i(vld), .stored_code_i(st), .calc_code_i(ca),
    .chk_done_o(a_done), .chk_status_o(a_stat), .err_byte_o(a_byte), .err_bit_o(a_bit),
    .fix_we_o(a_we), .fix_addr_o(a_addr), .fix_mask_o(a_mask));

  ham_sector_chk #(.PIPE(1)) i_ham_sector_chk_p (
    .clk_i(clk), .rst_ni(rst_n), .chk_valid_i(vld), .stored_code_i(st), .calc_code_i(ca),
    .chk_done_o(b_done), .chk_status_o(b_stat), .err_byte_o(b_byte), .err_bit_o(b_bit),
    .fix_we_o(b_we), .fix_addr_o(b_addr), .fix_mask_o(b_mask));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] unpack(input logic [23:0] c);
    return {4'h0, c[23:20], c[15:8], 4'h0, c[19:16], c[7:0]};
  endfunction

  function automatic logic [23:0] pack(input logic [31:0] w);
    return {w[27:24], w[11:8], w[23:16], w[7:0]};
  endfunction

  // expected {status, byte, bit}
  function automatic logic [14:0] model(input logic [23:0] s, input logic [23:0] c);
    logic [31:0] sy;
    int n;
    sy = unpack(s) ^ unpack(c);
    n = $countones(sy);
    if (sy == 0) return {3'd0, 12'd0};
    if (n == 12) return {3'd1, sy[27:19], sy[18:16]};
    if (n == 1) return {3'd2, 12'd0};
    if (unpack(s) == 32'h0FFF0FFF && unpack(c) == 0) return {3'd3, 12'd0};
    return {3'd4, 12'd0};
  endfunction

  task automatic check_res(input bit pb, input logic [14:0] e, input string req);
    logic [2:0] es; logic [8:0] eb; logic [2:0] ei;
    es = e[14:12]; eb = e[11:3]; ei = e[2:0];
    if (!pb) begin
      check(a_done == 1'b1, "R7", 32'(a_done), 1);
      check(a_stat == es, req, 32'(a_stat), 32'(es));
      check(a_byte == eb && a_bit == ei, req, {a_byte, a_bit}, {eb, ei});
      check(a_we == (es == 3'd1), "R8", 32'(a_we), 32'(es == 3'd1));
      if (es == 3'd1)
        check(a_addr == eb && a_mask == (8'd1 << ei), "R8", {a_addr, a_mask}, {eb, 8'd1 << ei});
    end else begin
      check(b_done == 1'b1, "R7", 32'(b_done), 1);
      check(b_stat == es, req, 32'(b_stat), 32'(es));
      check(b_byte == eb && b_bit == ei, req, {b_byte, b_bit}, {eb, ei});
      check(b_we == (es == 3'd1), "R8", 32'(b_we), 32'(es == 3'd1));
    end
  endtask

  task automatic run_case(input logic [23:0] s, input logic [23:0] c, input string req);
    logic [14:0] e;
    e = model(s, c);
    @(negedge clk); vld = 1'b1; st = s; ca = c;
    @(negedge clk); vld = 1'b0;
    check_res(0, e, req);
    @(negedge clk);
    check(a_done == 1'b0 && a_stat == e[14:12], "R7", {a_done, a_stat}, {1'b0, e[14:12]});
    check_res(1, e, req);
    @(negedge clk);
    check(b_done == 1'b0 && b_stat == e[14:12], "R7", {b_done, b_stat}, {1'b0, e[14:12]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vld = 1'b0; st = '0; ca = '0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(a_done == 0 && a_stat == 0 && a_byte == 0 && a_bit == 0 && a_we == 0 && a_mask == 0,
          "R9", {a_done, a_stat, a_we}, 0);
    check(b_done == 0 && b_stat == 0 && b_we == 0 && b_addr == 0, "R9", {b_done, b_stat, b_we}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(a_done == 0 && a_we == 0 && b_done == 0 && b_we == 0, "R9", {a_done, b_done}, 0);

    // R2 clean
    run_case(24'h000000, 24'h000000, "R2");
    run_case(24'h5A3C81, 24'h5A3C81, "R2");
    run_case(24'hFFFFFF, 24'hFFFFFF, "R2");

    // R1 R3 every data bit location
    for (int loc = 0; loc < 4096; loc++) begin
      logic [11:0] l;
      logic [31:0] sy, base;
      l = 12'(loc);
      sy = {4'h0, l, 4'h0, ~l};
      base = 32'(loc) * 32'h9E3779B1;
      run_case(pack(base), pack(base) ^ pack(sy), "R3");
    end

    // R4 single code bit faults
    for (int k = 0; k < 24; k++) begin
      run_case(24'h13579B, 24'h13579B ^ (24'd1 << k), "R4");
    end

    // R5 erased page and near misses
    run_case(24'hFFFFFF, 24'h000000, "R5");
    run_case(24'hFFFFFF, 24'h000001, "R6");
    run_case(24'hFFFF7F, 24'h000000, "R6");

    // R6 double faults
    for (int p = 0; p < 300; p++) begin
      logic [11:0] l1, l2;
      l1 = 12'(p * 37 + 5); l2 = 12'(p * 113 + 901);
      if (l1 == l2) l2 = l2 + 1;
      run_case(24'hA0B1C2, 24'hA0B1C2 ^ pack({4'h0, l1 ^ l2, 4'h0, l1 ^ l2}), "R6");
    end
    run_case(24'h000000, 24'h000003, "R6");

    // R10 back-to-back strobes
    begin
      logic [23:0] ss[3], cc[3];
      ss[0] = 24'h111111; cc[0] = 24'h111111;
      ss[1] = 24'hFFFFFF; cc[1] = 24'h000000;
      ss[2] = 24'h222222; cc[2] = 24'h222222 ^ pack({4'h0, 12'h155, 4'h0, 12'hEAA});
      @(negedge clk); vld = 1; st = ss[0]; ca = cc[0];
      @(negedge clk); st = ss[1]; ca = cc[1];
      check_res(0, model(ss[0], cc[0]), "R10");
      @(negedge clk); st = ss[2]; ca = cc[2];
      check_res(0, model(ss[1], cc[1]), "R10");
      check_res(1, model(ss[0], cc[0]), "R10");
      @(negedge clk); vld = 0;
      check_res(0, model(ss[2], cc[2]), "R10");
      check_res(1, model(ss[1], cc[1]), "R10");
      @(negedge clk);
      check_res(1, model(ss[2], cc[2]), "R10");
      check(a_done == 0, "R10", 32'(a_done), 0);
      @(negedge clk);
      check(b_done == 0, "R10", 32'(b_done), 0);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule